// File: doc/BRIEF.md
# DMA Channel Address Sequencer

This block produces the byte addresses that one DMA channel walks on its read side and on its write side. Software loads two offset registers. It then hands the sequencer a read base, a write base, a byte count for the write side and a small control field, and pulses `start`. From that point the data mover pulses `src_adv` each time it has consumed a read byte and `dst_adv` each time it has stored a write byte. The sequencer steps the matching address after each pulse.

Two controls shape the address streams. The first is an optional fixed displacement, equal to the positive offset minus the negative offset. It is applied once to the read base, to the write base, or to both, at the moment the transfer is accepted. The second is a stride mode for the read side. In this mode the read side takes N consecutive bytes, then jumps over the next N bytes, and repeats. The read span is therefore twice the write span. The transfer ends when the programmed number of write bytes has been advanced. `done` then stays high until the next start.

The controller has three named states. IDLE is entered at reset. RUN is active while a transfer is in progress. DONE holds after the last write byte. The transitions are:
- IDLE→RUN and DONE→RUN: `start` with a non-zero length.
- IDLE→DONE and DONE→DONE: `start` with a zero length.
- RUN→DONE: `dst_adv` on the final write byte.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `busy` and `done` are low, both addresses are zero, and both offset readbacks are zero.
- R2: A `start` accepted in IDLE or DONE loads `src_addr` and `dst_addr` from the bases on that clock edge and raises `busy`. This happens without displacement when `ctrl[19]` and `ctrl[20]` are both clear.
- R3: Asserting `ofs_we` writes `ofs_wdata` into the positive offset (`ofs_sel`=0) or the negative offset (`ofs_sel`=1). Only bits 21:4 are kept. The readbacks `pos_ofs` and `neg_ofs` return the masked value.
- R4: With `ctrl[19]` set, the loaded read address is the read base plus the positive offset minus the negative offset, modulo 2^ADDR_W. Offset writes made during a transfer do not move the current addresses.
- R5: With `ctrl[20]` set, the same displacement is applied to the loaded write address. Each of the two bits acts only on its own side.
- R6: In RUN, each `dst_adv` adds 1 to `dst_addr`. With `ctrl[18]` clear, each `src_adv` adds 1 to `src_addr`.
- R7: With `ctrl[18]` set, N is taken from `ctrl[17:16]` (0→1, 1→2, 2→4, 3→8 bytes). After k read advances, `src_addr` equals base + (k/N)·2N + (k mod N).
- R8: After `xfer_len` write advances, `busy` falls and `done` rises on the same edge. `done` holds until the next accepted start, and `busy` and `done` are never high together.
- R9: Outside RUN, `src_adv` and `dst_adv` leave both addresses unchanged.
- R10: A start with `xfer_len` = 0 goes directly to DONE, with `busy` low.
- R11: A `start` pulse during RUN is ignored. The addresses, the remaining count and `busy` are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted in IDLE or DONE) |
| src_base | input | ADDR_W | Read-side start address |
| dst_base | input | ADDR_W | Write-side start address |
| xfer_len | input | LEN_W | Number of write bytes |
| ctrl | input | 5 (bits 20:16) | 17:16 chunk code, 18 stride on, 19 read displacement, 20 write displacement |
| ofs_we | input | 1 | Offset register write strobe |
| ofs_sel | input | 1 | 0 = positive offset, 1 = negative offset |
| ofs_wdata | input | ADDR_W | Offset write data |
| src_adv | input | 1 | One read byte consumed |
| dst_adv | input | 1 | One write byte stored |
| src_addr | output | ADDR_W | Current read address |
| dst_addr | output | ADDR_W | Current write address |
| busy | output | 1 | State is RUN |
| done | output | 1 | State is DONE |
| pos_ofs | output | ADDR_W | Masked positive offset readback |
| neg_ofs | output | ADDR_W | Masked negative offset readback |

## Verification
Several properties are checked on every cycle. `busy` and `done` are exclusive, and `done` persists until a start. Addresses stay frozen outside RUN, and each RUN write advance moves the write address by exactly one. Every read step is one of the few legal step sizes. The offset readbacks never carry bits outside 21:4. The exact read sequence for each chunk code, the arithmetic of the displacement (including wrap below zero), the byte count that ends a transfer, and the rejection of a start during RUN depend on chosen stimulus. Only the bench's directed scenarios show those.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ag_state_e;

    localparam int CTRL_CHUNK_LO = 16;
    localparam int CTRL_STRIDE   = 18;
    localparam int CTRL_SRC_DISP = 19;
    localparam int CTRL_DST_DISP = 20;

    // chunk code 0..3 -> 1,2,4,8 bytes
    function automatic logic [3:0] chunk_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction
endpackage

// File: rtl/dma_ag_ofs_regs.sv
module dma_ag_ofs_regs #(
    parameter int ADDR_W = 32,
    parameter int OFS_LO = 4,
    parameter int OFS_HI = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] pos_q,
    output logic [ADDR_W-1:0] neg_q
);
    logic [ADDR_W-1:0] keep_mask;
    logic [ADDR_W-1:0] masked;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_mask
        assign keep_mask[i] = (i >= OFS_LO) && (i <= OFS_HI);
    end

    assign masked = wr_data & keep_mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
            neg_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) neg_q <= masked;
            else        pos_q <= masked;
        end
    end
endmodule

// File: rtl/dma_ag_src_walk.sv
module dma_ag_src_walk #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              stride_in,
    input  logic [1:0]        code_in,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    import dma_ag_pkg::*;

    logic [2:0] chunk_pos;
    logic       stride_q;
    logic [1:0] code_q;
    logic [3:0] n_bytes;
    logic       chunk_end;

    assign n_bytes   = chunk_bytes(code_q);
    assign chunk_end = stride_q && ({1'b0, chunk_pos} == (n_bytes - 4'd1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr      <= '0;
            chunk_pos <= '0;
            stride_q  <= 1'b0;
            code_q    <= '0;
        end else if (load) begin
            addr      <= load_addr;
            chunk_pos <= '0;
            stride_q  <= stride_in;
            code_q    <= code_in;
        end else if (adv) begin
            if (chunk_end) begin
                addr      <= addr + ADDR_W'(1) + ADDR_W'(n_bytes);
                chunk_pos <= '0;
            end else begin
                addr      <= addr + ADDR_W'(1);
                chunk_pos <= stride_q ? chunk_pos + 3'd1 : 3'd0;
            end
        end
    end
endmodule

// File: rtl/dma_ag_dst_walk.sv
module dma_ag_dst_walk #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              last_beat
);
    logic [LEN_W-1:0] remaining;

    assign last_beat = (remaining == LEN_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr      <= '0;
            remaining <= '0;
        end else if (load) begin
            addr      <= load_addr;
            remaining <= load_len;
        end else if (adv) begin
            addr      <= addr + ADDR_W'(1);
            remaining <= remaining - LEN_W'(1);
        end
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 24,
    parameter int OFS_LO = 4,
    parameter int OFS_HI = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic [20:16]      ctrl,
    input  logic              ofs_we,
    input  logic              ofs_sel,
    input  logic [ADDR_W-1:0] ofs_wdata,
    input  logic              src_adv,
    input  logic              dst_adv,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] pos_ofs,
    output logic [ADDR_W-1:0] neg_ofs
);
    import dma_ag_pkg::*;

    ag_state_e         state_q, state_d;
    logic              take;
    logic              src_go, dst_go;
    logic              last_beat;
    logic [ADDR_W-1:0] disp;
    logic [ADDR_W-1:0] src_ld, dst_ld;

    dma_ag_ofs_regs #(.ADDR_W(ADDR_W), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI)) u_ofs (
        .clk(clk), .rst_n(rst_n), .wr_en(ofs_we), .wr_sel(ofs_sel),
        .wr_data(ofs_wdata), .pos_q(pos_ofs), .neg_q(neg_ofs)
    );

    assign disp   = pos_ofs - neg_ofs;
    assign src_ld = src_base + (ctrl[CTRL_SRC_DISP] ? disp : '0);
    assign dst_ld = dst_base + (ctrl[CTRL_DST_DISP] ? disp : '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = (xfer_len == '0) ? ST_DONE : ST_RUN;
            end
            ST_RUN: begin
                if (dst_adv && last_beat) state_d = ST_DONE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        take   = 1'b0;
        src_go = 1'b0;
        dst_go = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE: take = start;
            ST_RUN: begin
                busy   = 1'b1;
                src_go = src_adv;
                dst_go = dst_adv;
            end
            ST_DONE: begin
                done = 1'b1;
                take = start;
            end
            default: ;
        endcase
    end

    dma_ag_src_walk #(.ADDR_W(ADDR_W)) u_src (
        .clk(clk), .rst_n(rst_n), .load(take), .load_addr(src_ld),
        .stride_in(ctrl[CTRL_STRIDE]), .code_in(ctrl[CTRL_CHUNK_LO+1:CTRL_CHUNK_LO]),
        .adv(src_go), .addr(src_addr)
    );

    dma_ag_dst_walk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dst (
        .clk(clk), .rst_n(rst_n), .load(take), .load_addr(dst_ld),
        .load_len(xfer_len), .adv(dst_go), .addr(dst_addr), .last_beat(last_beat)
    );
endmodule

// File: rtl/dma_ag_checker.sv
module dma_ag_checker #(
    parameter int ADDR_W = 32,
    parameter int OFS_LO = 4,
    parameter int OFS_HI = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              src_adv,
    input logic              dst_adv,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] dst_addr,
    input logic [ADDR_W-1:0] pos_ofs,
    input logic [ADDR_W-1:0] neg_ofs
);
    logic [ADDR_W-1:0] drop_mask;
    for (genvar i = 0; i < ADDR_W; i++) begin : g_drop
        assign drop_mask[i] = (i < OFS_LO) || (i > OFS_HI);
    end

    assert_ofs_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pos_ofs & drop_mask) == '0) && ((neg_ofs & drop_mask) == '0));

    assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    assert_frozen_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(src_addr) && $stable(dst_addr));

    assert_dst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && dst_adv |=> dst_addr == $past(dst_addr) + ADDR_W'(1));

    assert_src_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && src_adv |=> (src_addr - $past(src_addr) == ADDR_W'(1)) ||
                            (src_addr - $past(src_addr) == ADDR_W'(2)) ||
                            (src_addr - $past(src_addr) == ADDR_W'(3)) ||
                            (src_addr - $past(src_addr) == ADDR_W'(5)) ||
                            (src_addr - $past(src_addr) == ADDR_W'(9)));

    assert_src_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !src_adv |=> $stable(src_addr));
endmodule

bind dma_addr_gen dma_ag_checker #(.ADDR_W(ADDR_W), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .src_adv(src_adv), .dst_adv(dst_adv),
    .busy(busy), .done(done), .src_addr(src_addr), .dst_addr(dst_addr),
    .pos_ofs(pos_ofs), .neg_ofs(neg_ofs)
);

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic [LW-1:0] xfer_len = '0;
    logic [20:16]  ctrl = '0;
    logic          ofs_we = 1'b0, ofs_sel = 1'b0;
    logic [AW-1:0] ofs_wdata = '0;
    logic          src_adv = 1'b0, dst_adv = 1'b0;
    logic [AW-1:0] src_addr, dst_addr, pos_ofs, neg_ofs;
    logic          busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_addr_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
        .xfer_len(xfer_len), .ctrl(ctrl), .ofs_we(ofs_we), .ofs_sel(ofs_sel),
        .ofs_wdata(ofs_wdata), .src_adv(src_adv), .dst_adv(dst_adv),
        .src_addr(src_addr), .dst_addr(dst_addr), .busy(busy), .done(done),
        .pos_ofs(pos_ofs), .neg_ofs(neg_ofs)
    );

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_ofs(input bit sel, input logic [AW-1:0] d);
        ofs_sel = sel; ofs_wdata = d; ofs_we = 1'b1;
        @(negedge clk); ofs_we = 1'b0;
    endtask

    task automatic go(input logic [AW-1:0] s, input logic [AW-1:0] d,
                      input logic [LW-1:0] n, input logic [20:16] c);
        src_base = s; dst_base = d; xfer_len = n; ctrl = c; start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic step_src();
        src_adv = 1'b1; @(negedge clk); src_adv = 1'b0;
    endtask

    task automatic step_dst();
        dst_adv = 1'b1; @(negedge clk); dst_adv = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 busy", AW'(busy), 0);
        check("R1 done", AW'(done), 0);
        check("R1 src_addr", src_addr, 0);
        check("R1 dst_addr", dst_addr, 0);
        check("R1 pos_ofs", pos_ofs, 0);
        check("R1 neg_ofs", neg_ofs, 0);
    endtask

    task automatic t_ofs_regs();
        wr_ofs(0, 32'hFFFF_FFFF);
        check("R3 pos mask all ones", pos_ofs, 32'h003F_FFF0);
        wr_ofs(0, 32'h1234_5678);
        check("R3 pos mask", pos_ofs, 32'h0034_5670);
        wr_ofs(1, 32'h0000_012F);
        check("R3 neg mask", neg_ofs, 32'h0000_0120);
        check("R3 pos untouched by neg write", pos_ofs, 32'h0034_5670);
    endtask

    task automatic t_plain();
        go(32'h0000_1000, 32'h0000_8000, 3, 5'b00000);
        check("R2 src load", src_addr, 32'h1000);
        check("R2 dst load", dst_addr, 32'h8000);
        check("R2 busy", AW'(busy), 1);
        step_src(); step_src();
        check("R6 src +2", src_addr, 32'h1002);
        step_dst(); step_dst();
        check("R6 dst +2", dst_addr, 32'h8002);
        check("R8 busy before last", AW'(busy), 1);
        step_dst();
        check("R8 done", AW'(done), 1);
        check("R8 busy low", AW'(busy), 0);
        step_dst(); step_src();
        check("R9 dst frozen", dst_addr, 32'h8003);
        check("R9 src frozen", src_addr, 32'h1002);
        repeat (3) @(negedge clk);
        check("R8 done holds", AW'(done), 1);
    endtask

    task automatic t_disp();
        // pos=0x345670 neg=0x120
        go(32'h0000_1000, 32'h0000_8000, 2, 5'b01000);
        check("R4 src displaced", src_addr, 32'h1000 + 32'h0034_5670 - 32'h120);
        check("R5 dst untouched by bit19", dst_addr, 32'h8000);
        wr_ofs(0, 32'h0000_0000);
        check("R4 later write no move", src_addr, 32'h1000 + 32'h0034_5670 - 32'h120);
        step_dst(); step_dst();
        go(32'h0000_1000, 32'h0000_8000, 2, 5'b10000);
        check("R5 dst displaced", dst_addr, 32'h8000 - 32'h120);
        check("R5 src untouched by bit20", src_addr, 32'h1000);
        step_dst(); step_dst();
        wr_ofs(1, 32'h0000_0100);
        go(32'h0000_0010, 32'h0000_0020, 1, 5'b11000);
        check("R4 src wraps", src_addr, 32'hFFFF_FF10);
        check("R5 dst wraps", dst_addr, 32'hFFFF_FF20);
        step_dst();
    endtask

    task automatic t_stride(input int code);
        int n = 1 << code;
        go(32'h0000_4000, 32'h0000_9000, 4, {3'b001, 2'(code)});
        for (int k = 1; k <= 2*n + 1; k++) begin
            step_src();
            check($sformatf("R7 code%0d k=%0d", code, k), src_addr,
                  32'h4000 + AW'((k / n) * 2 * n + (k % n)));
        end
        repeat (4) step_dst();
        check("R8 done after stride run", AW'(done), 1);
    endtask

    task automatic t_zero_len();
        go(32'h0000_0500, 32'h0000_0600, 0, 5'b00000);
        check("R10 done", AW'(done), 1);
        check("R10 busy low", AW'(busy), 0);
        check("R10 src loaded", src_addr, 32'h500);
    endtask

    task automatic t_start_busy();
        go(32'h0000_2000, 32'h0000_3000, 2, 5'b00000);
        step_dst();
        go(32'h0000_7700, 32'h0000_7800, 9, 5'b00000);
        check("R11 src kept", src_addr, 32'h2000);
        check("R11 dst kept", dst_addr, 32'h3001);
        check("R11 busy", AW'(busy), 1);
        step_dst();
        check("R11 count kept", AW'(done), 1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_ofs_regs();
        t_plain();
        t_disp();
        for (int c = 0; c < 4; c++) t_stride(c);
        t_zero_len();
        t_start_busy();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule